// File: doc/BRIEF.md
# Pipelined Odd-Even Merge Sorting Network

This block sorts a vector of `NUM_ITEMS` unsigned words, each `WORD_W` bits wide, into ascending order. The words arrive in parallel on one flat input bus. The sorted vector leaves on one flat output bus a fixed number of cycles later. The network is made of compare-exchange elements. Each element has one magnitude comparator that drives the select of two 2:1 multiplexers. The elements are wired by Batcher's recursive odd-even merge construction, so one generic description covers every power-of-two lane count and no network is written out by hand for a given size.

A register stage closes each comparator layer, and lanes that have no comparator in a layer are registered in that stage as well. A fresh vector can therefore enter on every clock, and the time taken does not depend on the data. A valid flag travels alongside the data through a matching chain of flops.

To sort fewer items than there are lanes, fill the spare inputs with the all-ones word and ignore the same number of lanes at the top of the output.

Top module: `oddeven_sorter`

## Requirements
- R1: When `out_valid` is high, the output words are non-decreasing from lane 0 upward. Lane i occupies bits [i*WORD_W +: WORD_W] of each bus, so lane 0 holds the smallest word.
- R2: Each output vector is a permutation of the input vector it came from. Duplicate values keep their multiplicity.
- R3: A vector accepted at one rising edge appears at the output after exactly K*(K+1)/2 rising edges, where K = log2(NUM_ITEMS). With the default of 8 lanes this is 6 edges.
- R4: A new vector can be accepted on every clock. During an unbroken burst, each output equals the sorted form of its own input.
- R5: `out_valid` reproduces the `in_valid` pattern delayed by the latency of R3, including gaps. No result is dropped and none is invented.
- R6: An active-high synchronous reset clears the valid chain only. After reset, `out_valid` stays low until a vector presented after reset has crossed the whole pipeline.
- R7: Input lanes filled with the all-ones word leave on the topmost output lanes. The real items then appear sorted on the lowest lanes.
- R8: An instance with four lanes has 5 compare-exchange elements in 3 layers. Its latency is therefore 3 cycles, and it sorts correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid chain |
| in_valid | input | 1 | Marks `in_data` as a vector to sort |
| in_data | input | NUM_ITEMS*WORD_W | Unsorted words, lane i at bits [i*WORD_W +: WORD_W] |
| out_valid | output | 1 | Marks `out_data` as a sorted result |
| out_data | output | NUM_ITEMS*WORD_W | Sorted words, ascending from lane 0 |

## Verification
In any cycle inside a stream, accepting a new vector coincides with delivering an older one. A mid-stream reset can also coincide with vectors still in flight. The bench provokes the first case with unbroken bursts longer than the pipeline, and with bursts broken by random gaps. It judges each delivery against the entry that the scoreboard recorded for that vector, checking the data and the exact cycle in which it is due. The second case is provoked by raising reset while several vectors are in flight. It is judged by requiring `out_valid` to stay silent until new traffic has had time to cross the pipeline.

// File: rtl/sortnet_pkg.sv
package sortnet_pkg;

   // number of comparator layers for 2**lg lanes
   function automatic int layer_count(input int lg);
      return lg * (lg + 1) / 2;
   endfunction

   // merge block half-size p of layer s (outer loop of the construction)
   function automatic int layer_span(input int s);
      int c;
      int res;
      c = 0;
      res = 1;
      for (int lp = 0; lp < 31; lp++) begin
         for (int lk = lp; lk >= 0; lk--) begin
            if (c == s) res = 1 << lp;
            c++;
         end
      end
      return res;
   endfunction

   // comparator distance k of layer s (inner loop of the construction)
   function automatic int layer_dist(input int s);
      int c;
      int res;
      c = 0;
      res = 1;
      for (int lp = 0; lp < 31; lp++) begin
         for (int lk = lp; lk >= 0; lk--) begin
            if (c == s) res = 1 << lk;
            c++;
         end
      end
      return res;
   endfunction

   // true when lane a is the lower end of a comparator in a layer (p, k)
   function automatic bit cx_low(input int a, input int p, input int k, input int n);
      int j0;
      j0 = k % p;
      if (a < j0) return 1'b0;
      if (((a - j0) % (2 * k)) >= k) return 1'b0;
      if (a + k >= n) return 1'b0;
      return (a / (2 * p)) == ((a + k) / (2 * p));
   endfunction

   function automatic bit is_pow2(input int n);
      return (n >= 2) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/cx_elem.sv
module cx_elem #(
   parameter int WORD_W = 16
) (
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   output logic [WORD_W-1:0] lo,
   output logic [WORD_W-1:0] hi
);
   logic swap;

   // strict compare: equal words stay where they are
   assign swap = a > b;
   assign lo   = swap ? b : a;
   assign hi   = swap ? a : b;
endmodule

// File: rtl/sortnet_layer.sv
module sortnet_layer #(
   parameter int NUM_ITEMS = 8,
   parameter int WORD_W    = 16,
   parameter int SPAN      = 1,
   parameter int DIST      = 1
) (
   input  logic                        clk,
   input  logic [NUM_ITEMS*WORD_W-1:0] d_in,
   output logic [NUM_ITEMS*WORD_W-1:0] q_out
);
   localparam int BUS_W = NUM_ITEMS * WORD_W;

   logic [WORD_W-1:0] din [NUM_ITEMS];
   logic [WORD_W-1:0] nxt [NUM_ITEMS];
   logic [BUS_W-1:0]  nxt_bus;

   for (genvar a = 0; a < NUM_ITEMS; a++) begin : g_lane
      localparam bit IS_LO = sortnet_pkg::cx_low(a, SPAN, DIST, NUM_ITEMS);
      localparam bit IS_HI = sortnet_pkg::cx_low(a - DIST, SPAN, DIST, NUM_ITEMS);

      assign din[a] = d_in[a*WORD_W +: WORD_W];
      assign nxt_bus[a*WORD_W +: WORD_W] = nxt[a];

      if (IS_LO) begin : g_cx
         cx_elem #(.WORD_W(WORD_W)) u_cx (
            .a  (din[a]),
            .b  (din[a+DIST]),
            .lo (nxt[a]),
            .hi (nxt[a+DIST])
         );
      end else if (!IS_HI) begin : g_pass
         assign nxt[a] = din[a];
      end
   end

   // every lane is registered so all lanes stay aligned
   always_ff @(posedge clk) begin
      q_out <= nxt_bus;
   end
endmodule

// File: rtl/oddeven_sorter.sv
module oddeven_sorter #(
   parameter int NUM_ITEMS = 8,
   parameter int WORD_W    = 16
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        in_valid,
   input  logic [NUM_ITEMS*WORD_W-1:0] in_data,
   output logic                        out_valid,
   output logic [NUM_ITEMS*WORD_W-1:0] out_data
);
   localparam int LOG_N  = $clog2(NUM_ITEMS);
   localparam int STAGES = sortnet_pkg::layer_count(LOG_N);
   localparam int BUS_W  = NUM_ITEMS * WORD_W;

   if (!sortnet_pkg::is_pow2(NUM_ITEMS)) begin : g_bad_items
      $error("oddeven_sorter: NUM_ITEMS must be a power of two, at least 2");
   end
   if (WORD_W < 1) begin : g_bad_width
      $error("oddeven_sorter: WORD_W must be positive");
   end

   logic [BUS_W-1:0] stage_bus [STAGES+1];

   assign stage_bus[0] = in_data;

   for (genvar s = 0; s < STAGES; s++) begin : g_layer
      sortnet_layer #(
         .NUM_ITEMS (NUM_ITEMS),
         .WORD_W    (WORD_W),
         .SPAN      (sortnet_pkg::layer_span(s)),
         .DIST      (sortnet_pkg::layer_dist(s))
      ) u_layer (
         .clk   (clk),
         .d_in  (stage_bus[s]),
         .q_out (stage_bus[s+1])
      );
   end

   assign out_data = stage_bus[STAGES];

   // valid chain, the only state touched by reset
   if (STAGES == 1) begin : g_vld_single
      logic vld_q;
      always_ff @(posedge clk) begin
         if (rst) vld_q <= 1'b0;
         else     vld_q <= in_valid;
      end
      assign out_valid = vld_q;
   end else begin : g_vld_chain
      logic [STAGES-1:0] vld_q;
      always_ff @(posedge clk) begin
         if (rst) vld_q <= '0;
         else     vld_q <= {vld_q[STAGES-2:0], in_valid};
      end
      assign out_valid = vld_q[STAGES-1];
   end
endmodule

// File: rtl/sorter_checker.sv
module sorter_checker #(
   parameter int NUM_ITEMS = 8,
   parameter int WORD_W    = 16
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        in_valid,
   input logic [NUM_ITEMS*WORD_W-1:0] in_data,
   input logic                        out_valid,
   input logic [NUM_ITEMS*WORD_W-1:0] out_data
);
   localparam int LOG_N  = $clog2(NUM_ITEMS);
   localparam int STAGES = sortnet_pkg::layer_count(LOG_N);
   localparam int SUM_W  = WORD_W + LOG_N + 1;

   logic             ordered;
   logic [SUM_W-1:0] in_sum;
   logic [SUM_W-1:0] out_sum;
   logic [SUM_W-1:0] sum_pipe [STAGES];
   logic             vld_pipe [STAGES];
   int               since_rst;

   always_comb begin
      ordered = 1'b1;
      in_sum  = '0;
      out_sum = '0;
      for (int i = 0; i < NUM_ITEMS; i++) begin
         in_sum  = in_sum  + SUM_W'(in_data[i*WORD_W +: WORD_W]);
         out_sum = out_sum + SUM_W'(out_data[i*WORD_W +: WORD_W]);
      end
      for (int i = 0; i + 1 < NUM_ITEMS; i++) begin
         if (out_data[i*WORD_W +: WORD_W] > out_data[(i+1)*WORD_W +: WORD_W]) ordered = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      sum_pipe[0] <= in_sum;
      for (int i = 1; i < STAGES; i++) sum_pipe[i] <= sum_pipe[i-1];
      if (rst) begin
         for (int i = 0; i < STAGES; i++) vld_pipe[i] <= 1'b0;
         since_rst <= 0;
      end else begin
         vld_pipe[0] <= in_valid;
         for (int i = 1; i < STAGES; i++) vld_pipe[i] <= vld_pipe[i-1];
         if (since_rst < STAGES) since_rst <= since_rst + 1;
      end
   end

   assert_sorted_R1: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ordered);

   assert_sum_kept_R2: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_sum == sum_pipe[STAGES-1]));

   // also covers the fixed latency of R3
   assert_valid_delay_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid == vld_pipe[STAGES-1]);

   assert_quiet_after_reset_R6: assert property (@(posedge clk) disable iff (rst)
      (since_rst < STAGES) |-> !out_valid);
endmodule

bind oddeven_sorter sorter_checker #(
   .NUM_ITEMS (NUM_ITEMS),
   .WORD_W    (WORD_W)
) u_sorter_checker (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data)
);

// File: tb/oddeven_sorter_bench.sv
`timescale 1ns/1ps
module oddeven_sorter_bench;
   localparam int N    = 8;
   localparam int W    = 16;
   localparam int LAT  = 6;
   localparam int N4   = 4;
   localparam int LAT4 = 3;

   logic           clk = 1'b0;
   logic           rst;
   logic           in_valid;
   logic [N*W-1:0] in_data;
   logic           out_valid;
   logic [N*W-1:0] out_data;
   logic            out_valid4;
   logic [N4*W-1:0] out_data4;

   int  cyc = 0;
   int  checks = 0;
   int  errors = 0;
   bit  done = 1'b0;

   logic [N*W-1:0]  exp_q [$];
   int              due_q [$];
   string           tag_q [$];
   logic [N4*W-1:0] exp4_q [$];
   int              due4_q [$];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   oddeven_sorter #(.NUM_ITEMS(N), .WORD_W(W)) u_oddeven_sorter (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data));

   oddeven_sorter #(.NUM_ITEMS(N4), .WORD_W(W)) u_oddeven_sorter_n4 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data[N4*W-1:0]),
      .out_valid(out_valid4), .out_data(out_data4));

   function automatic logic [N*W-1:0] ref_sort(input logic [N*W-1:0] v, input int n);
      logic [W-1:0] w [N];
      logic [W-1:0] t;
      logic [N*W-1:0] r;
      for (int i = 0; i < N; i++) w[i] = (i < n) ? v[i*W +: W] : '0;
      for (int i = 1; i < n; i++) begin
         for (int j = i; j > 0; j--) begin
            if (w[j-1] > w[j]) begin
               t = w[j]; w[j] = w[j-1]; w[j-1] = t;
            end
         end
      end
      r = '0;
      for (int i = 0; i < n; i++) r[i*W +: W] = w[i];
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic [N*W-1:0] v, input bit vld, input string tag);
      logic [N*W-1:0] s4;
      @(negedge clk);
      in_valid = vld;
      in_data  = v;
      if (vld) begin
         exp_q.push_back(ref_sort(v, N));
         due_q.push_back(cyc + LAT);
         tag_q.push_back(tag);
         s4 = ref_sort(v, N4);
         exp4_q.push_back(s4[N4*W-1:0]);
         due4_q.push_back(cyc + LAT4);
      end
   endtask

   // scoreboard monitor, main instance
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R5", "unexpected out_valid", N*W'(1), '0);
            end else begin
               logic [N*W-1:0] e;
               int    d;
               string tg;
               bit    ord;
               e = exp_q.pop_front(); d = due_q.pop_front(); tg = tag_q.pop_front();
               check(d == cyc, "R3", "result cycle", N*W'(cyc), N*W'(d));
               check(out_data == e, tg, "sorted data (R2)", out_data, e);
               ord = 1'b1;
               for (int i = 0; i + 1 < N; i++)
                  if (out_data[i*W +: W] > out_data[(i+1)*W +: W]) ord = 1'b0;
               check(ord, "R1", "ascending order", out_data, e);
            end
         end else if (due_q.size() > 0 && due_q[0] == cyc) begin
            check(1'b0, "R5", "missing out_valid", '0, exp_q[0]);
            void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
         end
      end
   end

   // scoreboard monitor, four-lane instance
   always @(negedge clk) begin
      if (!rst && !done) begin
         if (out_valid4) begin
            if (exp4_q.size() == 0) begin
               check(1'b0, "R8", "unexpected out_valid (4 lanes)", N*W'(1), '0);
            end else begin
               logic [N4*W-1:0] e4;
               int d4;
               e4 = exp4_q.pop_front(); d4 = due4_q.pop_front();
               check(d4 == cyc, "R8", "3-cycle latency (4 lanes)", N*W'(cyc), N*W'(d4));
               check(out_data4 == e4, "R8", "sorted data (4 lanes)", N*W'(out_data4), N*W'(e4));
            end
         end else if (due4_q.size() > 0 && due4_q[0] == cyc) begin
            check(1'b0, "R8", "missing out_valid (4 lanes)", '0, N*W'(exp4_q[0]));
            void'(exp4_q.pop_front()); void'(due4_q.pop_front());
         end
      end
   end

   task automatic expect_quiet(input string req, input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check(!out_valid && !out_valid4, req, "out_valid low after reset",
               N*W'(out_valid), '0);
      end
   endtask

   function automatic logic [N*W-1:0] rand_vec(input int maxv);
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'($urandom_range(0, maxv));
      return v;
   endfunction

   initial begin
      logic [N*W-1:0] v;
      rst = 1'b1; in_valid = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      expect_quiet("R6", LAT);

      // directed patterns
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(i * 3);
      drive(v, 1'b1, "R1");
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(1000 - i * 7);
      drive(v, 1'b1, "R1");
      drive({N{16'h0042}}, 1'b1, "R2");
      drive(rand_vec(3), 1'b1, "R2");
      // padding: three real items, the rest all-ones
      v = {N{16'hFFFF}};
      v[0*W +: W] = 16'h0900; v[2*W +: W] = 16'h0011; v[5*W +: W] = 16'h0300;
      drive(v, 1'b1, "R7");
      drive({N{16'hFFFF}}, 1'b1, "R7");
      repeat (LAT + 2) drive(rand_vec(65535), 1'b0, "R5");

      // back-to-back burst, longer than the pipeline
      for (int i = 0; i < 60; i++) drive(rand_vec((i % 2) ? 7 : 65535), 1'b1, "R4");
      // gaps
      for (int i = 0; i < 80; i++) drive(rand_vec(65535), ($urandom_range(0, 2) != 0), "R5");
      repeat (LAT + 2) drive(rand_vec(65535), 1'b0, "R5");
      check(exp_q.size() == 0, "R5", "all results delivered", N*W'(exp_q.size()), '0);

      // reset with vectors in flight
      for (int i = 0; i < 4; i++) drive(rand_vec(65535), 1'b1, "R6");
      @(negedge clk);
      rst = 1'b1; in_valid = 1'b0;
      exp_q.delete(); due_q.delete(); tag_q.delete();
      exp4_q.delete(); due4_q.delete();
      @(negedge clk);
      rst = 1'b0;
      expect_quiet("R6", LAT);

      // traffic after reset
      for (int i = 0; i < 20; i++) drive(rand_vec(255), 1'b1, "R4");
      repeat (LAT + 2) drive('0, 1'b0, "R5");
      check(exp_q.size() == 0 && exp4_q.size() == 0, "R5", "queues drained",
            N*W'(exp_q.size() + exp4_q.size()), '0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule